// File: doc/BRIEF.md
# Shared-Buffer Virtual-Channel Input Port

This block is the receiving side of one port of a wormhole-switched network-on-chip router. The port carries several virtual channels (VCs). Their flit queues share a single payload memory that is cut into equal fixed regions, one per VC. Each VC has its own write pointer, read pointer and occupancy counter. An incoming flit names its VC, its kind (head, body, tail or single) and a payload. The port places the payload in that VC's region and keeps the kind bits next to the pointers. When a packet's head reaches the front of a VC, the port raises an allocation request. After a grant, it shows that VC as ready to the switch allocator. Each flit that leaves returns a credit upstream.

Each VC runs two small state machines. The arrival machine tracks whether the VC may be handed to a new packet: I_FREE moves to I_OPEN on a head. I_OPEN moves on the tail either to I_DRAIN or straight back to I_FREE, depending on the mode. I_DRAIN returns to I_FREE once the queue is empty. The departure machine moves from O_WAIT to O_GRANTED when an allocator grant meets a pending request. It moves back from O_GRANTED to O_WAIT when a tail flit is popped. The parameter `ATOMIC` picks the mode. When it is non-zero, a VC is freed only when its queue is empty. When it is zero, a VC is freed as soon as its tail has arrived.

Top module: `vc_input_port`

## Requirements
- R1: After reset every VC is empty: `alloc_req`, `flit_ready` and `credit_out` are all zero and every bit of `vc_free` is one.
- R2: Flits written to one VC leave it in arrival order. `front_data` and `front_type` show the oldest flit of the VC chosen by `sel_vc`. The flit-kind encoding is 2'b10 head, 2'b00 body, 2'b01 tail and 2'b11 single: bit 1 marks a packet start and bit 0 marks a packet end.
- R3: Each VC holds exactly `DEPTH` flits. A VC filled to `DEPTH` returns all of them intact. A write to a full VC is a protocol error and is dropped.
- R4: `alloc_req[v]` is high in the cycle after a head or single flit becomes the front of VC v while that VC is in O_WAIT. It stays high until `alloc_gnt[v]` is seen.
- R5: After a grant, `alloc_req[v]` is low and `flit_ready[v]` is high while VC v holds flits. Popping a tail or single flit returns the VC to O_WAIT. If another packet's head is queued behind it, a new request follows.
- R6: `credit_out[v]` pulses high for exactly one cycle, in the cycle after a flit is popped from VC v.
- R7: With `ATOMIC` non-zero, `vc_free[v]` falls in the cycle after a head is written. It stays low until the tail has arrived and the queue is empty.
- R8: With `ATOMIC` zero, `vc_free[v]` rises in the cycle after the tail is written, even if flits of that packet are still queued. A new packet may then be queued behind the old one.
- R9: A single flit opens and closes a packet in one flit. With `ATOMIC` zero, `vc_free` stays high. With `ATOMIC` non-zero, it stays low until the flit has left.
- R10: A write and a pop in the same cycle work independently, whether they hit the same VC or different VCs. On the same VC, the occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit present |
| in_vc | input | VC_W | VC index of the incoming flit |
| in_type | input | 2 | Kind of the incoming flit (R2 encoding) |
| in_data | input | DATA_W | Payload of the incoming flit |
| alloc_gnt | input | NUM_VC | Allocation grant per VC, at most one bit high |
| pop | input | 1 | Remove the front flit of VC `sel_vc` |
| sel_vc | input | VC_W | VC whose front flit is shown and popped |
| alloc_req | output | NUM_VC | Head flit waiting for allocation, per VC |
| flit_ready | output | NUM_VC | Granted VC holding at least one flit |
| front_type | output | 2 | Kind of the front flit of `sel_vc` |
| front_data | output | DATA_W | Payload of the front flit of `sel_vc` |
| vc_free | output | NUM_VC | VC may be assigned to a new packet |
| credit_out | output | NUM_VC | One-cycle credit return per VC |

## Verification
A flit arrival and a flit departure can land in the same cycle, either on one VC or on two different VCs. The bench provokes this by raising `in_valid` and `pop` together. It does this while a granted VC drains a four-flit packet, and again while a single flit arrives on a neighbouring VC. It judges the result in three ways. It checks the popped payloads against values it computes from the VC, packet length and flit position. It checks that the credit pulse still appears and that the readiness flag stays high. It checks that the neighbour raises its request in the following cycle. Two instances, one per reallocation mode, receive the same stimulus, so that the differing `vc_free` behaviour can be compared cycle by cycle.

// File: rtl/vcp_pkg.sv
package vcp_pkg;

    // bit 1 = packet start, bit 0 = packet end
    typedef enum logic [1:0] {
        FT_BODY   = 2'b00,
        FT_TAIL   = 2'b01,
        FT_HEAD   = 2'b10,
        FT_SINGLE = 2'b11
    } flit_kind_t;

    typedef enum logic [1:0] {
        I_FREE  = 2'b00,
        I_OPEN  = 2'b01,
        I_DRAIN = 2'b10
    } arr_state_t;

    typedef enum logic {
        O_WAIT    = 1'b0,
        O_GRANTED = 1'b1
    } dep_state_t;

endpackage

// File: rtl/vcp_flit_mem.sv
module vcp_flit_mem #(
    parameter int NUM_VC = 4,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 16,
    localparam int WORDS  = NUM_VC * DEPTH,
    localparam int ADDR_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_data = store[rd_addr];

endmodule

// File: rtl/vcp_vc_ctl.sv
module vcp_vc_ctl
    import vcp_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ATOMIC = 1,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  flit_kind_t       wr_kind,
    input  logic             rd,
    input  logic             gnt,
    output logic             wr_ok,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output flit_kind_t       front_kind,
    output logic             req,
    output logic             ready,
    output logic             free,
    output logic             credit
);

    flit_kind_t       kind_q [DEPTH];
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] tails_held;
    arr_state_t       ast, ast_nx;
    dep_state_t       dst, dst_nx;
    logic             in_start, in_end, fr_start, fr_end, nonempty;

    assign wr_ok    = wr && (cnt != CNT_W'(DEPTH));
    assign in_start = wr_kind[1];
    assign in_end   = wr_kind[0];
    assign fr_start = front_kind[1];
    assign fr_end   = front_kind[0];
    assign nonempty = (cnt != '0);
    assign front_kind = kind_q[rptr];

    // occupancy
    always_comb begin
        cnt_nx = cnt;
        if (wr_ok && !rd) begin
            cnt_nx = cnt + CNT_W'(1);
        end else if (!wr_ok && rd) begin
            cnt_nx = cnt - CNT_W'(1);
        end
    end

    // pointers, kinds, counters, credit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr       <= '0;
            rptr       <= '0;
            cnt        <= '0;
            tails_held <= '0;
            credit     <= 1'b0;
        end else begin
            if (wr_ok) begin
                wptr <= wptr + PTR_W'(1);
            end
            if (rd) begin
                rptr <= rptr + PTR_W'(1);
            end
            cnt        <= cnt_nx;
            tails_held <= tails_held + CNT_W'(wr_ok && in_end) - CNT_W'(rd && fr_end);
            credit     <= rd;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            kind_q[wptr] <= wr_kind;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ast <= I_FREE;
            dst <= O_WAIT;
        end else begin
            ast <= ast_nx;
            dst <= dst_nx;
        end
    end

    // next state: arrival side
    always_comb begin
        ast_nx = ast;
        unique case (ast)
            I_FREE: begin
                if (wr_ok && in_start) begin
                    if (in_end) begin
                        ast_nx = (ATOMIC != 0) ? I_DRAIN : I_FREE;
                    end else begin
                        ast_nx = I_OPEN;
                    end
                end
            end
            I_OPEN: begin
                if (wr_ok && in_end) begin
                    ast_nx = (ATOMIC != 0) ? I_DRAIN : I_FREE;
                end
            end
            I_DRAIN: begin
                if (cnt_nx == '0) begin
                    ast_nx = I_FREE;
                end
            end
            default: ast_nx = I_FREE;
        endcase
    end

    // next state: departure side
    always_comb begin
        dst_nx = dst;
        unique case (dst)
            O_WAIT: begin
                if (gnt && req) begin
                    dst_nx = O_GRANTED;
                end
            end
            O_GRANTED: begin
                if (rd && fr_end) begin
                    dst_nx = O_WAIT;
                end
            end
            default: dst_nx = O_WAIT;
        endcase
    end

    // outputs
    always_comb begin
        req   = (dst == O_WAIT) && nonempty && fr_start;
        ready = (dst == O_GRANTED) && nonempty;
        free  = (ast == I_FREE);
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (cnt != CNT_W'(DEPTH)));

    p_pop_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd |-> (dst == O_GRANTED && cnt != '0));

    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> req);

    p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !wr_ok) |=> (cnt == $past(cnt) - CNT_W'(1)));

    p_tails_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tails_held <= cnt);

    p_atomic_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ATOMIC != 0 && ast == I_FREE) |-> (cnt == '0));

    p_early_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ATOMIC == 0 && wr_ok && in_end) |=> (ast == I_FREE));

endmodule

// File: rtl/vc_input_port.sv
module vc_input_port
    import vcp_pkg::*;
#(
    parameter int NUM_VC = 4,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 16,
    parameter int ATOMIC = 1,
    localparam int VC_W   = $clog2(NUM_VC),
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int ADDR_W = VC_W + PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VC_W-1:0]   in_vc,
    input  logic [1:0]        in_type,
    input  logic [DATA_W-1:0] in_data,
    input  logic [NUM_VC-1:0] alloc_gnt,
    input  logic              pop,
    input  logic [VC_W-1:0]   sel_vc,
    output logic [NUM_VC-1:0] alloc_req,
    output logic [NUM_VC-1:0] flit_ready,
    output logic [1:0]        front_type,
    output logic [DATA_W-1:0] front_data,
    output logic [NUM_VC-1:0] vc_free,
    output logic [NUM_VC-1:0] credit_out
);

    logic [PTR_W-1:0] wptr_v [NUM_VC];
    logic [PTR_W-1:0] rptr_v [NUM_VC];
    flit_kind_t       kind_v [NUM_VC];
    logic [NUM_VC-1:0] wr_ok_v;
    flit_kind_t       in_kind;

    assign in_kind = flit_kind_t'(in_type);

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        vcp_vc_ctl #(
            .DEPTH  (DEPTH),
            .ATOMIC (ATOMIC)
        ) u_ctl (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr         (in_valid && (in_vc == VC_W'(v))),
            .wr_kind    (in_kind),
            .rd         (pop && (sel_vc == VC_W'(v))),
            .gnt        (alloc_gnt[v]),
            .wr_ok      (wr_ok_v[v]),
            .wptr       (wptr_v[v]),
            .rptr       (rptr_v[v]),
            .front_kind (kind_v[v]),
            .req        (alloc_req[v]),
            .ready      (flit_ready[v]),
            .free       (vc_free[v]),
            .credit     (credit_out[v])
        );
    end

    vcp_flit_mem #(
        .NUM_VC (NUM_VC),
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk     (clk),
        .wr_en   (|wr_ok_v),
        .wr_addr ({in_vc, wptr_v[in_vc]}),
        .wr_data (in_data),
        .rd_addr ({sel_vc, rptr_v[sel_vc]}),
        .rd_data (front_data)
    );

    assign front_type = kind_v[sel_vc];

    p_gnt_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_gnt));

    p_credit_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(credit_out) <= 1);

endmodule

// File: tb/vc_input_port_bench.sv
module vc_input_port_bench;

    localparam int NV = 4;
    localparam int DP = 4;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_vc = '0;
    logic [1:0]    in_type = '0;
    logic [DW-1:0] in_data = '0;
    logic [NV-1:0] gnt = '0;
    logic          pop = 1'b0;
    logic [1:0]    sel_vc = '0;
    logic          en_a = 1'b1;
    logic          en_n = 1'b1;

    logic [NV-1:0] req_a, rdy_a, free_a, cr_a, req_n, rdy_n, free_n, cr_n;
    logic [1:0]    ft_a, ft_n;
    logic [DW-1:0] fd_a, fd_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vc_input_port #(.NUM_VC(NV), .DEPTH(DP), .DATA_W(DW), .ATOMIC(1)) u_vc_input_port (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid & en_a), .in_vc(in_vc),
        .in_type(in_type), .in_data(in_data), .alloc_gnt(gnt & {NV{en_a}}),
        .pop(pop & en_a), .sel_vc(sel_vc), .alloc_req(req_a), .flit_ready(rdy_a),
        .front_type(ft_a), .front_data(fd_a), .vc_free(free_a), .credit_out(cr_a));

    vc_input_port #(.NUM_VC(NV), .DEPTH(DP), .DATA_W(DW), .ATOMIC(0)) u_vc_input_port_na (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid & en_n), .in_vc(in_vc),
        .in_type(in_type), .in_data(in_data), .alloc_gnt(gnt & {NV{en_n}}),
        .pop(pop & en_n), .sel_vc(sel_vc), .alloc_req(req_n), .flit_ready(rdy_n),
        .front_type(ft_n), .front_data(fd_n), .vc_free(free_n), .credit_out(cr_n));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] kind_of(input int len, input int k);
        if (len == 1) return 2'b11;
        if (k == 0) return 2'b10;
        if (k == len - 1) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] pay(input int v, input int len, input int k);
        return DW'(v * 256 + len * 16 + k);
    endfunction

    task automatic push(input int v, input logic [1:0] t, input logic [DW-1:0] d);
        in_valid = 1'b1; in_vc = 2'(v); in_type = t; in_data = d;
        tick();
        in_valid = 1'b0;
    endtask

    task automatic grant(input int v);
        gnt = NV'(1) << v;
        tick();
        gnt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1 req", {req_a, req_n}, '0);
        check("R1 ready", {rdy_a, rdy_n}, '0);
        check("R1 credit", {cr_a, cr_n}, '0);
        check("R1 free", {free_a, free_n}, 8'hFF);

        // sweep every VC and every packet length up to DEPTH (R3 boundary at len=DP)
        for (int v = 0; v < NV; v++) begin
            for (int len = 1; len <= DP; len++) begin
                for (int k = 0; k < len; k++) begin
                    push(v, kind_of(len, k), pay(v, len, k));
                    check("R7 free atomic", 32'(free_a[v]), 0);
                    check("R8 R9 free nonatomic", 32'(free_n[v]), 32'(k == len - 1));
                    check("R4 req", {req_a, req_n}, {NV'(1) << v, NV'(1) << v});
                    check("R4 ready low", {rdy_a, rdy_n}, '0);
                end
                sel_vc = 2'(v);
                #1;
                check("R2 head data", {fd_a, fd_n}, {pay(v, len, 0), pay(v, len, 0)});
                check("R2 head kind", {ft_a, ft_n}, {kind_of(len, 0), kind_of(len, 0)});
                grant(v);
                check("R5 req dropped", {req_a, req_n}, '0);
                check("R5 ready", {rdy_a, rdy_n}, {NV'(1) << v, NV'(1) << v});
                for (int k = 0; k < len; k++) begin
                    sel_vc = 2'(v); pop = 1'b1;
                    #1;
                    check("R2 R3 data", {fd_a, fd_n}, {pay(v, len, k), pay(v, len, k)});
                    check("R2 kind", {ft_a, ft_n}, {kind_of(len, k), kind_of(len, k)});
                    tick();
                    pop = 1'b0;
                    check("R6 credit", {cr_a, cr_n}, {NV'(1) << v, NV'(1) << v});
                end
                check("R5 ready after tail", {rdy_a, rdy_n}, '0);
                check("R7 R9 atomic free after drain", 32'(free_a[v]), 1);
                tick();
                check("R6 credit single pulse", {cr_a, cr_n}, '0);
                check("R5 no req", {req_a, req_n}, '0);
            end
        end

        // R8: non-atomic instance queues a second packet behind the first
        en_a = 1'b0;
        push(1, 2'b10, 16'h0A00);
        check("R8 open", 32'(free_n[1]), 0);
        push(1, 2'b01, 16'h0A01);
        check("R8 free at tail", 32'(free_n[1]), 1);
        push(1, 2'b10, 16'h0B00);
        check("R8 reopened", 32'(free_n[1]), 0);
        push(1, 2'b01, 16'h0B01);
        check("R8 free again", 32'(free_n[1]), 1);
        grant(1);
        sel_vc = 2'd1; pop = 1'b1; #1;
        check("R8 old head", 32'(fd_n), 32'h0A00);
        tick();
        #1;
        check("R8 old tail", 32'(fd_n), 32'h0A01);
        tick();
        pop = 1'b0;
        check("R5 new req after tail pop", 32'(req_n), 32'h2);
        check("R5 ready low after tail pop", 32'(rdy_n), 0);
        check("R8 atomic untouched", 32'(free_a), 32'hF);
        grant(1);
        pop = 1'b1; #1;
        check("R8 new head", 32'(fd_n), 32'h0B00);
        tick();
        #1;
        check("R8 new tail", 32'(fd_n), 32'h0B01);
        tick();
        pop = 1'b0;
        check("R8 drained", 32'(rdy_n), 0);
        tick();
        en_a = 1'b1;

        // R10: write and pop in the same cycle
        push(2, 2'b10, pay(2, 4, 0));
        push(2, 2'b00, pay(2, 4, 1));
        grant(2);
        in_valid = 1'b1; in_vc = 2'd2; in_type = 2'b00; in_data = pay(2, 4, 2);
        pop = 1'b1; sel_vc = 2'd2; #1;
        check("R10 front head", {fd_a, fd_n}, {pay(2, 4, 0), pay(2, 4, 0)});
        tick();
        in_type = 2'b01; in_data = pay(2, 4, 3); #1;
        check("R10 credit", {cr_a, cr_n}, {4'h4, 4'h4});
        check("R10 ready kept", {rdy_a, rdy_n}, {4'h4, 4'h4});
        check("R10 front body", {fd_a, fd_n}, {pay(2, 4, 1), pay(2, 4, 1)});
        tick();
        check("R8 tail in, flits queued", 32'(free_n[2]), 1);
        check("R7 tail in, flits queued", 32'(free_a[2]), 0);
        in_vc = 2'd3; in_type = 2'b11; in_data = pay(3, 1, 0); #1;
        check("R10 front body2", {fd_a, fd_n}, {pay(2, 4, 2), pay(2, 4, 2)});
        tick();
        in_valid = 1'b0;
        check("R10 neighbour req", {req_a, req_n}, {4'h8, 4'h8});
        check("R10 credit cross", {cr_a, cr_n}, {4'h4, 4'h4});
        check("R9 single atomic busy", 32'(free_a[3]), 0);
        check("R9 single nonatomic free", 32'(free_n[3]), 1);
        #1;
        check("R10 front tail", {fd_a, ft_a}, {pay(2, 4, 3), 2'b01});
        tick();
        pop = 1'b0;
        check("R5 VC2 done", {rdy_a, rdy_n}, '0);
        check("R7 free after drain", 32'(free_a[2]), 1);
        check("R4 req held", {req_a, req_n}, {4'h8, 4'h8});
        grant(3);
        check("R5 ready VC3", {rdy_a, rdy_n}, {4'h8, 4'h8});
        sel_vc = 2'd3; pop = 1'b1; #1;
        check("R9 single kind", {ft_a, ft_n}, 4'hF);
        tick();
        pop = 1'b0;
        check("R9 single gone", {rdy_a, rdy_n, req_a, req_n}, '0);
        check("R9 atomic free", 32'(free_a), 32'hF);
        check("R6 credit VC3", {cr_a, cr_n}, {4'h8, 4'h8});
        tick();
        check("R6 credit end", {cr_a, cr_n}, '0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule